// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches virtual-to-physical page translations for a processor's memory path. Pages are 4 KB, and the array has 16 sets of 4 ways. A lookup presents a 32-bit virtual address together with an access kind, a privilege mode and an address-space tag. In the same cycle the block answers with exactly one of four outcomes: a hit with the translated physical address, a miss, a permission fault, or a dirty-update request.

An external page walker services misses and dirty-update requests. It writes the translation it finds through the fill port. A maintenance port removes stale translations. It can remove a single page of one address space, every entry of one address space, or the whole array. Entries carry their address-space tag, so switching between processes does not require flushing the array.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: Virtual address bits [15:12] select the set and bits [31:16] form the tag. On a hit, `lk_paddr` is the stored 20-bit frame number joined to address bits [11:0]. For any other outcome `lk_paddr` is zero.
- R3: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss`, `lk_fault` and `lk_dirty_req` is high. While `lk_valid` is low, all four are low.
- R4: A lookup matches an entry only if the entry is valid and both its tag and its address-space tag equal those of the lookup. The same page may be held under several address-space tags, each with its own frame.
- R5: A fill is written only when `fl_ok` is 1. If the set already holds the same page and address-space tag, the fill overwrites that entry.
- R6: `lk_kind` is encoded as 0 = read, 1 = write, 2 or 3 = execute. The access needs the matching permission bit (R, W or X). When `lk_user` is 1 the entry's user bit must also be 1, while a kernel access (`lk_user` = 0) ignores the user bit. A matching entry that breaks either rule reports a fault.
- R7: A permitted write to a matching entry whose dirty bit is 0 reports `lk_dirty_req` instead of a hit. After a refill with the dirty bit set, the same write hits.
- R8: A fill of a new page takes the lowest-numbered invalid way of its set. If all four ways are valid, it replaces the way chosen by a per-set 3-bit tree pseudo-LRU. That state is reset to point at way 0 and is updated on every hit and on every fill.
- R9: `inv_op` is encoded as 1 = remove the page `inv_vpn` under `inv_asid`, 2 = remove every entry tagged `inv_asid`, 3 = remove all entries. The removal is visible to lookups in the next cycle.
- R10: When `inv_op` is nonzero, a fill presented in the same cycle is discarded.
- R11: When a hit and a fill fall in the same cycle and the same set, the hit updates the pseudo-LRU state first, and the fill's victim is chosen from that updated state.
- R12: A lookup sees the array as it stood before the current clock edge. A fill becomes visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| lk_user | input | 1 | 1 = user-mode access, 0 = kernel |
| lk_asid | input | 8 | Address-space tag of the lookup |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry denies the access |
| lk_dirty_req | output | 1 | Write to a clean page; walker must mark it dirty |
| lk_paddr | output | 32 | Physical address on hit, else zero |
| fl_valid | input | 1 | Fill request from walker |
| fl_vpn | input | 20 | Virtual page number of the fill |
| fl_asid | input | 8 | Address-space tag of the fill |
| fl_pfn | input | 20 | Physical frame number of the fill |
| fl_ok | input | 1 | Walker result is a valid translation |
| fl_r | input | 1 | Read permission |
| fl_w | input | 1 | Write permission |
| fl_x | input | 1 | Execute permission |
| fl_u | input | 1 | User-accessible page |
| fl_d | input | 1 | Dirty bit |
| inv_op | input | 2 | Invalidate command: 0 none, 1 page, 2 address space, 3 all |
| inv_vpn | input | 20 | Page number for the page command |
| inv_asid | input | 8 | Address-space tag for the page and address-space commands |

## Verification
Two sets of functions can land on the same cycle. The first is a lookup hit and a walker fill to the same set, where the hit's recency update has to steer the fill's victim. The second is an invalidate command alongside a fill, where the fill must be dropped. The bench provokes the first case by filling all four ways of a set, then presenting a hit on way 0 together with a fifth page in one cycle. It judges the outcome by which older page later misses (way 2, not way 0). It provokes the second case by issuing a page invalidate of an unrelated page in the same cycle as a fill, then confirming that the filled page still misses. A behavioural model that updates recency before choosing a victim is compared on every clock.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int SET_W  = 4,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [1:0]        lk_kind,
  input  logic              lk_user,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic              lk_dirty_req,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              fl_valid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [PFN_W-1:0]  fl_pfn,
  input  logic              fl_ok,
  input  logic              fl_r,
  input  logic              fl_w,
  input  logic              fl_x,
  input  logic              fl_u,
  input  logic              fl_d,
  input  logic [1:0]        inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid
);
  localparam int NWAY  = 4;
  localparam int NSET  = 1 << SET_W;
  localparam int NENT  = NSET * NWAY;
  localparam int IDX_W = SET_W + 2;
  localparam int TAG_W = VPN_W - SET_W;

  logic              e_v    [NENT];
  logic [TAG_W-1:0]  e_tag  [NENT];
  logic [ASID_W-1:0] e_asid [NENT];
  logic [PFN_W-1:0]  e_pfn  [NENT];
  logic              e_r [NENT], e_w [NENT], e_x [NENT], e_u [NENT], e_d [NENT];
  logic [2:0]        plru   [NSET];

  function automatic logic [1:0] first_set(input logic [NWAY-1:0] m);
    return m[0] ? 2'd0 : m[1] ? 2'd1 : m[2] ? 2'd2 : 2'd3;
  endfunction

  // bit0 root (1: victim on right pair), bit1 left pair, bit2 right pair
  function automatic logic [2:0] touch(input logic [2:0] s, input logic [1:0] w);
    logic [2:0] t;
    t = s;
    t[0] = ~w[1];
    if (!w[1]) t[1] = ~w[0];
    else       t[2] = ~w[0];
    return t;
  endfunction

  function automatic logic [1:0] victim(input logic [2:0] s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction

  wire [SET_W-1:0] l_set = lk_vaddr[OFF_W +: SET_W];
  wire [TAG_W-1:0] l_tag = lk_vaddr[VA_W-1 -: TAG_W];
  wire [SET_W-1:0] f_set = fl_vpn[SET_W-1:0];
  wire [TAG_W-1:0] f_tag = fl_vpn[VPN_W-1:SET_W];

  logic [NWAY-1:0] l_m, f_m, f_free;
  always_comb begin
    for (int w = 0; w < NWAY; w++) begin
      l_m[w]    = e_v[{l_set, 2'(w)}] && e_tag[{l_set, 2'(w)}] == l_tag &&
                  e_asid[{l_set, 2'(w)}] == lk_asid;
      f_m[w]    = e_v[{f_set, 2'(w)}] && e_tag[{f_set, 2'(w)}] == f_tag &&
                  e_asid[{f_set, 2'(w)}] == fl_asid;
      f_free[w] = !e_v[{f_set, 2'(w)}];
    end
  end

  wire [1:0]       l_way = first_set(l_m);
  wire [IDX_W-1:0] l_idx = {l_set, l_way};
  wire             l_any = |l_m;
  wire             need_x = lk_kind[1];
  wire             need_w = !lk_kind[1] && lk_kind[0];
  wire             l_perm = (need_x ? e_x[l_idx] : need_w ? e_w[l_idx] : e_r[l_idx]) &&
                            (!lk_user || e_u[l_idx]);
  wire             l_clean_wr = need_w && !e_d[l_idx];

  assign lk_miss      = lk_valid && !l_any;
  assign lk_fault     = lk_valid && l_any && !l_perm;
  assign lk_dirty_req = lk_valid && l_any && l_perm && l_clean_wr;
  assign lk_hit       = lk_valid && l_any && l_perm && !l_clean_wr;
  assign lk_paddr     = lk_hit ? {e_pfn[l_idx], lk_vaddr[OFF_W-1:0]} : '0;

  wire [2:0] f_base = (lk_hit && l_set == f_set) ? touch(plru[l_set], l_way) : plru[f_set];
  wire [1:0] f_way  = (|f_m) ? first_set(f_m) : (|f_free) ? first_set(f_free) : victim(f_base);
  wire [IDX_W-1:0] f_idx = {f_set, f_way};
  wire       f_go   = fl_valid && fl_ok && inv_op == 2'd0;

  logic kill [NENT];
  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      unique case (inv_op)
        2'd1:    kill[e] = SET_W'(e / NWAY) == inv_vpn[SET_W-1:0] &&
                           e_tag[e] == inv_vpn[VPN_W-1:SET_W] && e_asid[e] == inv_asid;
        2'd2:    kill[e] = e_asid[e] == inv_asid;
        2'd3:    kill[e] = 1'b1;
        default: kill[e] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) e_v[e] <= 1'b0;
      for (int s = 0; s < NSET; s++) plru[s] <= 3'd0;
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (kill[e])                              e_v[e] <= 1'b0;
        else if (f_go && IDX_W'(e) == f_idx)      e_v[e] <= 1'b1;
      end
      if (lk_hit) plru[l_set] <= touch(plru[l_set], l_way);
      if (f_go)   plru[f_set] <= touch(f_base, f_way);
    end
  end

  always_ff @(posedge clk) begin
    if (f_go) begin
      e_tag[f_idx]  <= f_tag;
      e_asid[f_idx] <= fl_asid;
      e_pfn[f_idx]  <= fl_pfn;
      e_r[f_idx]    <= fl_r;
      e_w[f_idx]    <= fl_w;
      e_x[f_idx]    <= fl_x;
      e_u[f_idx]    <= fl_u;
      e_d[f_idx]    <= fl_d;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic              lk_fault,
  input logic              lk_dirty_req,
  input logic [PFN_W+OFF_W-1:0] lk_paddr,
  input logic              fl_valid,
  input logic              fl_ok,
  input logic [VA_W-OFF_W-1:0] fl_vpn,
  input logic [ASID_W-1:0] fl_asid,
  input logic [1:0]        inv_op
);
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_fault, lk_dirty_req}) == 1);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_dirty_req));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  p_paddr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_paddr == '0);

  p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_op == 2'd3 |=> !(lk_hit || lk_fault || lk_dirty_req));

  p_fill_visible_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fl_valid && fl_ok && inv_op == 2'd0) && lk_valid &&
     lk_vaddr[VA_W-1:OFF_W] == $past(fl_vpn) && lk_asid == $past(fl_asid)) |-> !lk_miss);
endmodule

bind xlate_cache xlate_cache_chk u_chk (.*);

// File: tb/test_xlate_cache.sv
module test_xlate_cache;
  localparam int NONE = 0, HIT = 1, MISS = 2, FAULT = 3, DIRTY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0; logic [31:0] lk_vaddr = 0; logic [1:0] lk_kind = 0;
  logic lk_user = 0; logic [7:0] lk_asid = 0;
  logic lk_hit, lk_miss, lk_fault, lk_dirty_req; logic [31:0] lk_paddr;
  logic fl_valid = 0; logic [19:0] fl_vpn = 0; logic [7:0] fl_asid = 0; logic [19:0] fl_pfn = 0;
  logic fl_ok = 0, fl_r = 0, fl_w = 0, fl_x = 0, fl_u = 0, fl_d = 0;
  logic [1:0] inv_op = 0; logic [19:0] inv_vpn = 0; logic [7:0] inv_asid = 0;

  int total = 0, bad = 0;
  string cur_tag = "R3";
  bit done = 0;

  always #5 clk = ~clk;

  xlate_cache i_xlate_cache (.*);

  // reference model
  bit mv[64]; int mtag[64]; int masid[64]; int mpfn[64];
  bit mr[64], mw[64], mx[64], mu[64], md[64];
  int mroot[16], mleft[16], mright[16];

  function automatic void m_look(input logic [31:0] va, input int kind, input bit user,
                                 input int asid, output int code, output logic [31:0] pa,
                                 output int way);
    int s; bit ok;
    s = int'(va[15:12]); way = -1; pa = 0;
    for (int w = 0; w < 4; w++)
      if (way < 0 && mv[s*4+w] && mtag[s*4+w] == int'(va[31:16]) && masid[s*4+w] == asid) way = w;
    if (way < 0) begin code = MISS; return; end
    if (kind >= 2) ok = mx[s*4+way]; else if (kind == 1) ok = mw[s*4+way]; else ok = mr[s*4+way];
    if (user && !mu[s*4+way]) ok = 0;
    if (!ok) code = FAULT;
    else if (kind == 1 && !md[s*4+way]) code = DIRTY;
    else begin code = HIT; pa = {20'(mpfn[s*4+way]), va[11:0]}; end
  endfunction

  function automatic void m_touch(input int s, input int w);
    mroot[s] = (w < 2) ? 1 : 0;
    if (w < 2) mleft[s] = (w == 0) ? 1 : 0; else mright[s] = (w == 2) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 64; e++) mv[e] = 0;
      for (int s = 0; s < 16; s++) begin mroot[s] = 0; mleft[s] = 0; mright[s] = 0; end
    end else begin
      int code, way, s, w; logic [31:0] pa;
      if (lk_valid) begin
        m_look(lk_vaddr, int'(lk_kind), lk_user, int'(lk_asid), code, pa, way);
        if (code == HIT) m_touch(int'(lk_vaddr[15:12]), way);
      end
      if (inv_op != 0) begin
        for (int e = 0; e < 64; e++) begin
          if (inv_op == 3) mv[e] = 0;
          else if (inv_op == 2 && masid[e] == int'(inv_asid)) mv[e] = 0;
          else if (inv_op == 1 && e / 4 == int'(inv_vpn[3:0]) &&
                   mtag[e] == int'(inv_vpn[19:4]) && masid[e] == int'(inv_asid)) mv[e] = 0;
        end
      end else if (fl_valid && fl_ok) begin
        s = int'(fl_vpn[3:0]); w = -1;
        for (int k = 0; k < 4; k++)
          if (w < 0 && mv[s*4+k] && mtag[s*4+k] == int'(fl_vpn[19:4]) && masid[s*4+k] == int'(fl_asid)) w = k;
        for (int k = 0; k < 4; k++) if (w < 0 && !mv[s*4+k]) w = k;
        if (w < 0) w = mroot[s] ? 2 + mright[s] : mleft[s];
        mv[s*4+w] = 1; mtag[s*4+w] = int'(fl_vpn[19:4]); masid[s*4+w] = int'(fl_asid);
        mpfn[s*4+w] = int'(fl_pfn);
        mr[s*4+w] = fl_r; mw[s*4+w] = fl_w; mx[s*4+w] = fl_x; mu[s*4+w] = fl_u; md[s*4+w] = fl_d;
        m_touch(s, w);
      end
    end
  end

  function automatic int dut_code();
    return lk_hit ? HIT : lk_miss ? MISS : lk_fault ? FAULT : lk_dirty_req ? DIRTY : NONE;
  endfunction

  // per-cycle comparison against the model, including the R3 one-outcome rule
  always @(negedge clk) if (rst_n && !done) begin
    int code, way; logic [31:0] pa;
    if (lk_valid) m_look(lk_vaddr, int'(lk_kind), lk_user, int'(lk_asid), code, pa, way);
    else begin code = NONE; pa = 0; end
    total++;
    if (dut_code() != code || lk_paddr != pa ||
        (int'(lk_hit) + int'(lk_miss) + int'(lk_fault) + int'(lk_dirty_req)) != (lk_valid ? 1 : 0)) begin
      bad++;
      $display("FAIL %s model: got code=%0d pa=%h flags=%b%b%b%b expected code=%0d pa=%h",
               cur_tag, dut_code(), lk_paddr, lk_hit, lk_miss, lk_fault, lk_dirty_req, code, pa);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn,
                      input bit ok, input bit r, input bit w, input bit x, input bit u, input bit d);
    fl_valid = 1; fl_vpn = vpn; fl_asid = asid; fl_pfn = pfn;
    fl_ok = ok; fl_r = r; fl_w = w; fl_x = x; fl_u = u; fl_d = d;
    tick(); fl_valid = 0;
  endtask

  task automatic inv(input logic [1:0] op, input logic [19:0] vpn, input logic [7:0] asid);
    inv_op = op; inv_vpn = vpn; inv_asid = asid; tick(); inv_op = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] kind, input bit user,
                      input logic [7:0] asid, input int exp, input logic [31:0] epa, input string tag);
    lk_valid = 1; lk_vaddr = va; lk_kind = kind; lk_user = user; lk_asid = asid; cur_tag = tag;
    @(negedge clk);
    total++;
    if (dut_code() != exp || (exp == HIT && lk_paddr != epa)) begin
      bad++;
      $display("FAIL %s va=%h: got code=%0d pa=%h expected code=%0d pa=%h",
               tag, va, dut_code(), lk_paddr, exp, epa);
    end
    tick(); lk_valid = 0; cur_tag = "R3";
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    look(32'h1234_5000, 0, 0, 8'd3, MISS, 0, "R1");
    look(32'h0000_0000, 2, 1, 8'd0, MISS, 0, "R1");
    // R2 / R4
    fill(20'h12345, 8'd3, 20'hABCDE, 1, 1, 1, 1, 1, 1);
    look(32'h1234_57FF, 0, 1, 8'd3, HIT, 32'hABCD_E7FF, "R2");
    look(32'h1234_5000, 0, 1, 8'd4, MISS, 0, "R4");
    fill(20'h12345, 8'd4, 20'h11111, 1, 1, 1, 1, 1, 1);
    look(32'h1234_5123, 0, 1, 8'd4, HIT, 32'h1111_1123, "R4");
    look(32'h1234_5123, 0, 1, 8'd3, HIT, 32'hABCD_E123, "R4");
    // R5 invalid walker result is not stored
    fill(20'h00042, 8'd1, 20'h00999, 0, 1, 1, 1, 1, 1);
    look(32'h0004_2000, 0, 0, 8'd1, MISS, 0, "R5");
    // R6 permissions
    fill(20'h00011, 8'd1, 20'h00500, 1, 1, 0, 0, 0, 1);
    look(32'h0001_1ABC, 0, 1, 8'd1, FAULT, 0, "R6");
    look(32'h0001_1ABC, 0, 0, 8'd1, HIT, 32'h0050_0ABC, "R6");
    look(32'h0001_1ABC, 1, 0, 8'd1, FAULT, 0, "R6");
    look(32'h0001_1ABC, 2, 0, 8'd1, FAULT, 0, "R6");
    fill(20'h00021, 8'd1, 20'h00600, 1, 0, 0, 1, 1, 1);
    look(32'h0002_1004, 3, 1, 8'd1, HIT, 32'h0060_0004, "R6");
    look(32'h0002_1004, 0, 1, 8'd1, FAULT, 0, "R6");
    // R7 dirty update, R5 overwrite on refill
    fill(20'h00033, 8'd1, 20'h00777, 1, 1, 1, 0, 1, 0);
    look(32'h0003_3010, 1, 1, 8'd1, DIRTY, 0, "R7");
    look(32'h0003_3010, 0, 1, 8'd1, HIT, 32'h0077_7010, "R7");
    fill(20'h00033, 8'd1, 20'h00778, 1, 1, 1, 0, 1, 1);
    look(32'h0003_3010, 1, 1, 8'd1, HIT, 32'h0077_8010, "R7");
    look(32'h0003_3FFF, 0, 1, 8'd1, HIT, 32'h0077_8FFF, "R5");
    // R8 replacement in set 9
    for (int k = 1; k <= 4; k++) fill(20'(k * 32'h10000 + 9), 8'd2, 20'(32'h100 + k), 1, 1, 1, 1, 1, 1);
    look(32'h1000_9000, 0, 1, 8'd2, HIT, 32'h0010_1000, "R8");
    fill(20'h50009, 8'd2, 20'h00105, 1, 1, 1, 1, 1, 1);
    look(32'h3000_9000, 0, 1, 8'd2, MISS, 0, "R8");
    look(32'h1000_9000, 0, 1, 8'd2, HIT, 32'h0010_1000, "R8");
    look(32'h2000_9000, 0, 1, 8'd2, HIT, 32'h0010_2000, "R8");
    look(32'h4000_9000, 0, 1, 8'd2, HIT, 32'h0010_4000, "R8");
    look(32'h5000_9000, 0, 1, 8'd2, HIT, 32'h0010_5000, "R8");
    // R11 hit and fill in one cycle, set 7
    for (int k = 1; k <= 4; k++) fill(20'(k * 32'h10000 + 7), 8'd5, 20'(32'h200 + k), 1, 1, 1, 1, 1, 1);
    fl_valid = 1; fl_vpn = 20'h50007; fl_asid = 8'd5; fl_pfn = 20'h00205;
    fl_ok = 1; fl_r = 1; fl_w = 1; fl_x = 1; fl_u = 1; fl_d = 1;
    look(32'h1000_7000, 0, 1, 8'd5, HIT, 32'h0020_1000, "R11");
    fl_valid = 0;
    look(32'h3000_7000, 0, 1, 8'd5, MISS, 0, "R11");
    look(32'h1000_7000, 0, 1, 8'd5, HIT, 32'h0020_1000, "R11");
    look(32'h5000_7000, 0, 1, 8'd5, HIT, 32'h0020_5000, "R11");
    // R12 fill visible only next cycle
    fl_valid = 1; fl_vpn = 20'h60006; fl_asid = 8'd5; fl_pfn = 20'h00306;
    look(32'h6000_6000, 0, 1, 8'd5, MISS, 0, "R12");
    fl_valid = 0;
    look(32'h6000_6000, 0, 1, 8'd5, HIT, 32'h0030_6000, "R12");
    // R10 invalidate beats fill
    fl_valid = 1; fl_vpn = 20'h70000; fl_asid = 8'd6; fl_pfn = 20'h00400;
    inv(2'd1, 20'hFFFFF, 8'd9);
    fl_valid = 0;
    look(32'h7000_0000, 0, 1, 8'd6, MISS, 0, "R10");
    // R9 invalidation commands
    inv(2'd1, 20'h12345, 8'd3);
    look(32'h1234_5000, 0, 1, 8'd3, MISS, 0, "R9");
    look(32'h1234_5000, 0, 1, 8'd4, HIT, 32'h1111_1000, "R9");
    inv(2'd2, 20'h0, 8'd2);
    look(32'h1000_9000, 0, 1, 8'd2, MISS, 0, "R9");
    look(32'h5000_7000, 0, 1, 8'd5, HIT, 32'h0020_5000, "R9");
    inv(2'd3, 20'h0, 8'd0);
    look(32'h5000_7000, 0, 1, 8'd5, MISS, 0, "R9");
    look(32'h0001_1000, 0, 0, 8'd1, MISS, 0, "R9");
    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule